// File: doc/BRIEF.md
# Serial Flash SPI Master with Byte FIFOs

This block drives a serial flash device over a four-wire SPI link. Software controls it through a 32-bit register port. Outgoing bytes go into an 8-entry transmit queue. Bytes captured from the device collect in an 8-entry receive queue. A serial engine takes one byte at a time from the transmit queue, shifts it out and, when the frame direction says to keep input, stores the byte captured on the data-in line.

The serial clock is programmable: its half-period is `divider + 1` system clocks, and its polarity and phase are selectable. Frames can be 1 to 8 bits long, sent MSB-first or LSB-first.

The chip select has three modes:

- **Auto** frames every byte on its own.
- **Hold** keeps the device selected across a multi-byte flash command, such as opcode, address and data.
- **Off** never selects the device.

Watermark flags on both queues can raise an interrupt, so software can learn that the transmit queue has drained or that input is waiting. Only single-lane transfers are carried out. The dual and quad codes are stored in the format register and read back, but they do not change the wire behaviour.

Top module: `spi_flash_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1 and `spi_sck` is 0. The TX data register (offset 0x48) reads with bit 31 clear. The RX data register (offset 0x4C) reads with bit 31 set. The pending register (offset 0x74) reads 0 and `irq` is 0.
- R2: A write to offset 0x48 enqueues bits 7:0 and ignores the upper bits. A read of 0x48 returns bit 31 set while the 8-entry TX queue is full. A write made while the queue is full is dropped and produces no frame.
- R3: In the format register (offset 0x40), bit 2 = 0 selects MSB-first, bit 3 = 0 selects receive, and bits 19:16 hold the frame length (8 here). With these settings each queued byte is shifted out MSB-first and the byte captured on `spi_miso` enters the RX queue. A read of 0x4C pops one entry into bits 7:0 with bit 31 clear.
- R4: With bit 2 of 0x40 set, bits are shifted LSB-first in both directions. With clock-mode register (offset 0x04) bit 0 = polarity and bit 1 = phase both set, data is captured on the trailing clock edge.
- R5: While no frame is in progress, `spi_sck` rests at the polarity value in bit 0 of 0x04.
- R6: During a frame, every `spi_sck` transition is `divider + 1` system clocks after the previous one. The divider is set at offset 0x00.
- R7: With chip-select mode (offset 0x18) = 2 (hold), `spi_cs_n` stays low between consecutive frames and after the last one. It rises only once the mode is written back to 0.
- R8: With mode 0 (auto), `spi_cs_n` falls before each frame and rises after its last bit, once per byte.
- R9: With mode 3 (off), frames still clock `spi_sck`, but `spi_cs_n` never goes low.
- R10: With bit 3 of 0x40 set (transmit), captured bits are discarded and the RX queue stays empty.
- R11: Pending bit 0 is 1 while the TX queue holds fewer entries than the TX watermark (offset 0x50, bits 15:0). With a watermark of 1 it is 1 only when the queue is empty.
- R12: Pending bit 1 is 1 while the RX queue holds more entries than the RX watermark (offset 0x54, bits 15:0).
- R13: `irq` is 1 exactly when some pending bit is 1 and the matching bit of the enable register (offset 0x70) is set.
- R14: A frame length of 4 in bits 19:16 of 0x40 shifts the low 4 bits of the byte and captures 4 bits into the low nibble of the RX entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq | output | 1 | Interrupt request |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low device select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
A device model on the serial pins recovers every frame under the configured polarity, phase, bit order and length, and matches it against the byte queued by the driver. A swapped bit order or a phase error therefore shows up as a wrong byte, not as a hang.

The bench fills the transmit queue past its depth while a slow frame is running. A queue that accepted the extra byte would show up as a ninth frame followed by an unexpected tenth.

Other checks:
- The chip select is watched across consecutive frames in hold mode, where a design that released it per byte would break the flash command.
- In off mode a low-going select at any moment is counted as an error.
- A receive queue filled during transmit-direction frames would surface as a non-empty read.
- A divider off by one would show up in the measured edge spacing.

// File: rtl/spi_fm_pkg.sv
`timescale 1ns/1ps
// Shared types and register offsets of the SPI flash master.
// Assumes a byte-addressed register port with word-aligned offsets.
package spi_fm_pkg;

    typedef enum logic [1:0] {
        CS_AUTO = 2'd0,
        CS_RSVD = 2'd1,
        CS_HOLD = 2'd2,
        CS_OFF  = 2'd3
    } cs_mode_t;

    typedef struct packed {
        logic [3:0] len;
        logic       dir_tx;
        logic       lsb_first;
        logic [1:0] proto;
    } fmt_t;

    localparam logic [7:0] OFS_DIV    = 8'h00;
    localparam logic [7:0] OFS_CLKMD  = 8'h04;
    localparam logic [7:0] OFS_CSMD   = 8'h18;
    localparam logic [7:0] OFS_FMT    = 8'h40;
    localparam logic [7:0] OFS_TXD    = 8'h48;
    localparam logic [7:0] OFS_RXD    = 8'h4C;
    localparam logic [7:0] OFS_TXCTL  = 8'h50;
    localparam logic [7:0] OFS_RXCTL  = 8'h54;
    localparam logic [7:0] OFS_IE     = 8'h70;
    localparam logic [7:0] OFS_IP     = 8'h74;

endpackage

// File: rtl/spi_fm_fifo.sv
`timescale 1ns/1ps
// Synchronous FIFO with occupancy count.
// Assumes DEPTH >= 2. A push while full and a pop while empty are ignored.
// dout always shows the oldest entry.
module spi_fm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/spi_fm_engine.sv
`timescale 1ns/1ps
// Serial engine: takes one byte per frame from the TX queue, shifts it out
// single-lane, captures input and drives the chip select per its mode.
// Frame settings (length, phase, order, direction) are latched when a frame
// starts. Clock polarity and chip-select mode act live.
module spi_fm_engine
    import spi_fm_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             lsb_first,
    input  logic             dir_tx,
    input  logic [3:0]       frame_len,
    input  cs_mode_t         cs_mode,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    output logic             busy,
    output logic             dir_tx_l,
    output logic             sck,
    output logic             mosi,
    output logic             cs_n,
    input  logic             miso
);
    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL} st_t;

    st_t              state;
    logic [DIV_W-1:0] cnt;
    logic [4:0]       edge_n;
    logic [3:0]       bit_k;
    logic [3:0]       len_l;
    logic             cpha_l, lsb_l;
    logic             sck_ph, cs_act;
    logic [7:0]       tx_sh, rx_sh;
    logic             tick, last_edge, samp, launch;
    logic [3:0]       eff_len;

    // Map a bit index within the frame onto a byte position.
    function automatic logic [2:0] bpos(input logic [3:0] idx, input logic [3:0] n,
                                        input logic lsb);
        logic [3:0] t;
        t = n - 4'd1 - idx;
        return lsb ? idx[2:0] : t[2:0];
    endfunction

    assign eff_len   = (frame_len == 4'd0 || frame_len > 4'd8) ? 4'd8 : frame_len;
    assign tick      = (cnt == div);
    assign last_edge = (edge_n == (5'({len_l, 1'b0}) - 5'd1));
    assign samp      = ~edge_n[0] ^ cpha_l;
    assign launch    = ~samp && (cpha_l ? (edge_n != 5'd0) : !last_edge);

    assign tx_pop   = (state == ST_IDLE) && tx_valid;
    assign rx_push  = (state == ST_TRAIL) && tick && !dir_tx_l;
    assign rx_data  = rx_sh;
    assign busy     = (state != ST_IDLE);
    assign sck      = sck_ph ^ cpol;
    assign mosi     = tx_sh[bpos(bit_k, len_l, lsb_l)];
    assign cs_n     = ~cs_act;

    // Frame sequencer: lead-in, clock edges, tail, then select release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            edge_n   <= '0;
            bit_k    <= '0;
            len_l    <= 4'd8;
            cpha_l   <= 1'b0;
            lsb_l    <= 1'b0;
            dir_tx_l <= 1'b1;
            sck_ph   <= 1'b0;
            cs_act   <= 1'b0;
            tx_sh    <= '0;
            rx_sh    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (cs_mode != CS_HOLD) cs_act <= 1'b0;
                    if (tx_valid) begin
                        tx_sh    <= tx_data;
                        rx_sh    <= '0;
                        len_l    <= eff_len;
                        cpha_l   <= cpha;
                        lsb_l    <= lsb_first;
                        dir_tx_l <= dir_tx;
                        edge_n   <= '0;
                        bit_k    <= '0;
                        cs_act   <= (cs_mode != CS_OFF);
                        state    <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        cnt   <= '0;
                        state <= ST_XFER;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_XFER: begin
                    if (tick) begin
                        cnt    <= '0;
                        sck_ph <= ~sck_ph;
                        if (samp)   rx_sh[bpos(edge_n[4:1], len_l, lsb_l)] <= miso;
                        if (launch) bit_k <= bit_k + 1'b1;
                        if (last_edge) state <= ST_TRAIL;
                        else           edge_n <= edge_n + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (tick) begin
                        cnt <= '0;
                        if (cs_mode != CS_HOLD) cs_act <= 1'b0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_flash_master.sv
`timescale 1ns/1ps
// SPI flash master: register file, TX and RX byte queues, serial engine,
// watermark flags and interrupt.
// Assumes one-cycle register accesses. Read data is combinational, and a read
// of the RX data register pops the queue at the end of that cycle.
module spi_flash_master
    import spi_fm_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DIV_W      = 12,
    parameter int FIFO_DEPTH = 8,
    parameter int WM_W       = 16,
    parameter int DIV_RESET  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [DIV_W-1:0] div_q;
    logic             cpol_q, cpha_q;
    cs_mode_t         cs_mode_q;
    fmt_t             fmt_q;
    logic [WM_W-1:0]  txwm_q, rxwm_q;
    logic [1:0]       ie_q, ip;
    logic             wr_en, rd_en, tx_push, rx_pop;
    logic [7:0]       tx_head, rx_head, rx_in;
    logic [CNT_W-1:0] tx_count, rx_count;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             eng_pop, eng_push, eng_busy, eng_dir_l;
    logic             wdata_unused, rx_full_unused;

    assign wr_en   = reg_sel && reg_we;
    assign rd_en   = reg_sel && !reg_we;
    assign tx_push = wr_en && (reg_addr == ADDR_W'(OFS_TXD));
    assign rx_pop  = rd_en && (reg_addr == ADDR_W'(OFS_RXD));

    assign wdata_unused   = ^reg_wdata[31:20];
    assign rx_full_unused = rx_full;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= DIV_W'(DIV_RESET);
            cpol_q    <= 1'b0;
            cpha_q    <= 1'b0;
            cs_mode_q <= CS_AUTO;
            fmt_q     <= '{len: 4'd8, dir_tx: 1'b1, lsb_first: 1'b0, proto: 2'd0};
            txwm_q    <= '0;
            rxwm_q    <= '0;
            ie_q      <= '0;
        end else if (wr_en) begin
            case (reg_addr)
                ADDR_W'(OFS_DIV):   div_q     <= reg_wdata[DIV_W-1:0];
                ADDR_W'(OFS_CLKMD): {cpha_q, cpol_q} <= reg_wdata[1:0];
                ADDR_W'(OFS_CSMD):  cs_mode_q <= cs_mode_t'(reg_wdata[1:0]);
                ADDR_W'(OFS_FMT):   fmt_q     <= '{len: reg_wdata[19:16], dir_tx: reg_wdata[3],
                                                   lsb_first: reg_wdata[2], proto: reg_wdata[1:0]};
                ADDR_W'(OFS_TXCTL): txwm_q    <= reg_wdata[WM_W-1:0];
                ADDR_W'(OFS_RXCTL): rxwm_q    <= reg_wdata[WM_W-1:0];
                ADDR_W'(OFS_IE):    ie_q      <= reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    spi_fm_fifo #(.W(8), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .din(reg_wdata[7:0]),
        .pop(eng_pop), .dout(tx_head),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    spi_fm_fifo #(.W(8), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(eng_push), .din(rx_in),
        .pop(rx_pop), .dout(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    spi_fm_engine #(.DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .div(div_q), .cpol(cpol_q), .cpha(cpha_q),
        .lsb_first(fmt_q.lsb_first), .dir_tx(fmt_q.dir_tx), .frame_len(fmt_q.len),
        .cs_mode(cs_mode_q),
        .tx_valid(!tx_empty), .tx_data(tx_head), .tx_pop(eng_pop),
        .rx_push(eng_push), .rx_data(rx_in),
        .busy(eng_busy), .dir_tx_l(eng_dir_l),
        .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n), .miso(spi_miso)
    );

    // Watermark flags and interrupt request.
    always_comb begin
        ip[0] = WM_W'(tx_count) < txwm_q;
        ip[1] = WM_W'(rx_count) > rxwm_q;
        irq   = |(ip & ie_q);
    end

    // Read data selection.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_DIV):   reg_rdata[DIV_W-1:0] = div_q;
            ADDR_W'(OFS_CLKMD): reg_rdata[1:0] = {cpha_q, cpol_q};
            ADDR_W'(OFS_CSMD):  reg_rdata[1:0] = cs_mode_q;
            ADDR_W'(OFS_FMT):   reg_rdata = {12'd0, fmt_q.len, 12'd0, fmt_q.dir_tx,
                                             fmt_q.lsb_first, fmt_q.proto};
            ADDR_W'(OFS_TXD):   reg_rdata[31] = tx_full;
            ADDR_W'(OFS_RXD):   reg_rdata = rx_empty ? 32'h8000_0000 : {24'd0, rx_head};
            ADDR_W'(OFS_TXCTL): reg_rdata[WM_W-1:0] = txwm_q;
            ADDR_W'(OFS_RXCTL): reg_rdata[WM_W-1:0] = rxwm_q;
            ADDR_W'(OFS_IE):    reg_rdata[1:0] = ie_q;
            ADDR_W'(OFS_IP):    reg_rdata[1:0] = ip;
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_fm_checks.sv
`timescale 1ns/1ps
// Protocol checker for spi_flash_master, attached by bind.
// Observes pins and internal queue and engine state.
module spi_fm_checks
    import spi_fm_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sck,
    input logic          cs_n,
    input logic          cpol,
    input logic          busy,
    input cs_mode_t      cs_mode,
    input logic          tx_empty,
    input logic          dir_tx_l,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count
);
    AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(DEPTH)); // R2
    AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH)); // R3
    AST_SCK_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cpol)); // R5
    AST_CS_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_mode == CS_HOLD && $past(cs_mode == CS_HOLD) && !$past(cs_n)) |-> !cs_n); // R7
    AST_CS_AUTO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cs_mode != CS_HOLD && tx_empty) |=> cs_n); // R8
    AST_TX_DIR_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        dir_tx_l |=> (rx_count <= $past(rx_count))); // R10
endmodule

bind spi_flash_master spi_fm_checks #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .cpol(cpol_q),
    .busy(eng_busy), .cs_mode(cs_mode_q), .tx_empty(tx_empty), .dir_tx_l(eng_dir_l),
    .tx_count(tx_count), .rx_count(rx_count)
);

// File: tb/sim_spi_flash_master.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected MOSI bytes, and a device model
// on the pins pops and compares them as frames complete.
module sim_spi_flash_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0, fails = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    logic [7:0] miso_q[$];
    int  s_len = 8;
    bit  s_cpol = 0, s_cpha = 0, s_lsb = 0;
    string cur_req = "R3";

    int frames = 0, cs_rises = 0, cs_low_cycles = 0, sck_edges = 0, cyc = 0;
    bit meas_en = 0, iv_valid = 0;
    int iv_min = 0, iv_max = 0, iv_last = 0;
    int bitcnt = 0;
    logic [7:0] got = '0, cur_m = '0, e_b = '0, mask = '0;
    logic prev_sck = 1'b0, prev_cs = 1'b1;

    spi_flash_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic int bpos(input int k);
        return s_lsb ? k : (s_len - 1 - k);
    endfunction

    // Device model: frame recovery, scoreboard compare, MISO drive, pin stats.
    always @(negedge clk) begin
        cyc++;
        if (!spi_cs_n) cs_low_cycles++;
        if (spi_cs_n && !prev_cs) cs_rises++;
        if (spi_sck != prev_sck) begin
            sck_edges++;
            if (meas_en && !spi_cs_n) begin
                if (iv_valid) begin
                    if (cyc - iv_last < iv_min) iv_min = cyc - iv_last;
                    if (cyc - iv_last > iv_max) iv_max = cyc - iv_last;
                end
                iv_last  = cyc;
                iv_valid = 1;
            end
        end
        if (spi_cs_n) begin
            bitcnt = 0;
            got    = '0;
        end else if (spi_sck != prev_sck) begin
            if ((spi_sck != s_cpol) != s_cpha) begin
                got[bpos(bitcnt)] = spi_mosi;
                bitcnt++;
                if (bitcnt == s_len) begin
                    frames++;
                    mask = 8'((1 << s_len) - 1);
                    if (exp_q.size() == 0) begin
                        chk(0, "R2 unexpected frame", {24'd0, got}, 32'd0);
                    end else begin
                        e_b = exp_q.pop_front();
                        chk(got == (e_b & mask), cur_req, {24'd0, got}, {24'd0, e_b & mask});
                    end
                    if (miso_q.size() > 0) void'(miso_q.pop_front());
                    bitcnt = 0;
                    got    = '0;
                end
            end
        end
        prev_sck = spi_sck;
        prev_cs  = spi_cs_n;
        cur_m    = (miso_q.size() > 0) ? miso_q[0] : 8'h00;
        spi_miso = cur_m[bpos(bitcnt)];
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 0; reg_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1; reg_we = 0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_sel = 0;
    endtask

    // Driver: records the expected MOSI byte, then queues it with junk upper bits.
    task automatic send(input logic [7:0] b);
        exp_q.push_back(b);
        wr(8'h48, {24'hC0FFEE, b});
    endtask

    task automatic wait_frames(input int target);
        while (frames < target) @(negedge clk);
        repeat (60) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all) actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int base, e0, c0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1 cs_n", {31'd0, spi_cs_n}, 1);
        chk(spi_sck == 1'b0, "R1 sck", {31'd0, spi_sck}, 0);
        rd(8'h48, d); chk(d[31] == 1'b0, "R1 tx full bit", d, 0);
        rd(8'h4C, d); chk(d[31] == 1'b1, "R1 rx empty bit", d, 32'h8000_0000);
        rd(8'h74, d); chk(d == 0, "R1 pending", d, 0);
        chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 0);

        wr(8'h00, 0);
        wr(8'h50, 1);
        wr(8'h54, 1);
        rd(8'h74, d); chk(d[0] == 1'b1, "R11 tx drained flag", d, 1);

        // R3, R8, R12: MSB-first receive in auto mode
        wr(8'h40, 32'h0008_0000);
        cur_req = "R3 mosi byte";
        miso_q.push_back(8'hA5); miso_q.push_back(8'h3C);
        base = frames; c0 = cs_rises;
        send(8'h9F); send(8'h01);
        wait_frames(base + 2);
        chk(cs_rises - c0 == 2, "R8 one release per byte", cs_rises - c0, 2);
        rd(8'h74, d); chk(d[1] == 1'b1, "R12 rx above watermark", d, 3);
        rd(8'h4C, d); chk(d == 32'h0000_00A5, "R3 rx pop 1", d, 32'hA5);
        rd(8'h74, d); chk(d[1] == 1'b0, "R12 rx at watermark", d, 1);
        rd(8'h4C, d); chk(d == 32'h0000_003C, "R3 rx pop 2", d, 32'h3C);

        // R4, R5, R11: LSB-first, clock mode 3
        wr(8'h04, 3); s_cpol = 1; s_cpha = 1;
        wr(8'h40, 32'h0008_0004); s_lsb = 1;
        repeat (2) @(negedge clk);
        chk(spi_sck == 1'b1, "R5 idle level follows polarity", {31'd0, spi_sck}, 1);
        cur_req = "R4 mosi byte";
        miso_q.push_back(8'h81); miso_q.push_back(8'h7E); miso_q.push_back(8'hC3);
        base = frames;
        send(8'h12); send(8'h34); send(8'h56);
        rd(8'h74, d); chk(d[0] == 1'b0, "R11 flag low while queued", d, 0);
        wait_frames(base + 3);
        rd(8'h4C, d); chk(d == 32'h81, "R4 rx 1", d, 32'h81);
        rd(8'h4C, d); chk(d == 32'h7E, "R4 rx 2", d, 32'h7E);
        rd(8'h4C, d); chk(d == 32'hC3, "R4 rx 3", d, 32'hC3);
        chk(spi_sck == 1'b1, "R5 rest after frames", {31'd0, spi_sck}, 1);

        // R7, R10: hold mode, transmit direction
        wr(8'h04, 0); s_cpol = 0; s_cpha = 0;
        wr(8'h40, 32'h0008_0008); s_lsb = 0;
        wr(8'h18, 2);
        cur_req = "R7 mosi byte";
        base = frames; c0 = cs_rises;
        send(8'h02); send(8'h00); send(8'h10); send(8'hEE);
        wait_frames(base + 4);
        chk(cs_rises == c0, "R7 no release between frames", cs_rises - c0, 0);
        chk(spi_cs_n == 1'b0, "R7 held after last frame", {31'd0, spi_cs_n}, 0);
        wr(8'h18, 0);
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R7 release on mode change", {31'd0, spi_cs_n}, 1);
        rd(8'h4C, d); chk(d[31] == 1'b1, "R10 rx stays empty", d, 32'h8000_0000);

        // R9: off mode
        wr(8'h18, 3);
        c0 = cs_low_cycles; e0 = sck_edges;
        wr(8'h48, 32'h55); wr(8'h48, 32'hAA);
        repeat (200) @(negedge clk);
        chk(cs_low_cycles == c0, "R9 select never low", cs_low_cycles - c0, 0);
        chk(sck_edges - e0 == 32, "R9 clock still runs", sck_edges - e0, 32);

        // R6: divider 4
        wr(8'h18, 0);
        wr(8'h00, 4);
        iv_min = 1000000; iv_max = 0; iv_valid = 0; meas_en = 1;
        cur_req = "R6 mosi byte";
        base = frames;
        send(8'hC6);
        wait_frames(base + 1);
        meas_en = 0;
        chk(iv_min == 5 && iv_max == 5, "R6 half period", iv_max * 256 + iv_min, 32'h505);

        // R2: full queue, dropped write
        wr(8'h00, 2);
        cur_req = "R2 mosi byte";
        base = frames;
        for (int i = 0; i < 9; i++) send(8'(8'h20 + i));
        rd(8'h48, d); chk(d[31] == 1'b1, "R2 full flag", d, 32'h8000_0000);
        wr(8'h48, 32'h77);
        wait_frames(base + 9);
        repeat (300) @(negedge clk);
        chk(frames - base == 9, "R2 write while full dropped", frames - base, 9);
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

        // R13: interrupt gating
        wr(8'h70, 1);
        repeat (2) @(negedge clk);
        chk(irq == 1'b1, "R13 irq on enabled tx flag", {31'd0, irq}, 1);
        wr(8'h70, 2);
        repeat (2) @(negedge clk);
        chk(irq == 1'b0, "R13 irq masked", {31'd0, irq}, 0);
        wr(8'h70, 0);

        // R14: 4-bit frame
        wr(8'h00, 0);
        wr(8'h40, 32'h0004_0000); s_len = 4;
        cur_req = "R14 mosi nibble";
        miso_q.push_back(8'h05);
        base = frames;
        send(8'h0A);
        wait_frames(base + 1);
        rd(8'h4C, d); chk(d == 32'h05, "R14 rx nibble", d, 32'h05);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule